// File: doc/BRIEF.md
# Hot-Plug Attention Button Sequencer

This block runs the power sequence of one hot-pluggable slot under the control of an operator push button. The button input is synchronized and debounced. A press on an unpowered slot asks for power-up, and a press on a powered slot asks for power-down. The request stays pending for a cancel window, and a second press inside that window withdraws it. While a request is pending, and while power is ramping, the power indicator blinks. When the sequence settles, the indicator is solid on (powered) or dark (unpowered).

The block also protects the slot. A power-up request is refused if no adapter is detected or the retention latch is open. Power that fails to report good before a timeout is withdrawn. An unexpected latch opening cuts main and auxiliary power at once. Each of these cases lights the attention indicator. Each outcome is reported as a one-cycle event carrying a code, so a supervisor can log the sequence.

All timing is counted in milliseconds from a prescaled tick derived from `CLK_HZ` and `TICK_HZ`.

Top module: `slot_attn_seq`

## Requirements
- R1: After reset, `pwr_en`, `pwr_led`, `attn_led` and `evt_valid` are all low.
- R2: A change of the button level that lasts less than `DEBOUNCE_MS` milliseconds is ignored. It produces no event and no change of power or indicators. A press is taken at the debounced rising edge.
- R3: A press while the slot is unpowered, with `present_in` high and `latch_open_in` low, opens a cancel window of `CANCEL_MS` milliseconds. When the window ends, `pwr_en` rises.
- R4: While a request window or a power ramp is in progress, `pwr_led` toggles every `BLINK_HALF_MS` milliseconds. During a power-up window, `pwr_en` stays low.
- R5: Once `pwr_en` is high and `pgood_in` is seen high, the slot is powered and `pwr_led` is solid on. Event code 2 (add done) is emitted.
- R6: A second press inside the cancel window withdraws the request. Power stays as it was, the indicator returns to its prior solid state, and event code 1 (cancel) is emitted.
- R7: A press while the slot is powered opens a cancel window. When the window ends, `pwr_en` and `pwr_led` go low and event code 3 (remove done) is emitted.
- R8: A power-up request with `present_in` low or `latch_open_in` high is refused, either at the press or at the end of the window. The slot stays unpowered, `attn_led` lights and event code 4 (refused) is emitted. The next accepted power-up press clears `attn_led`.
- R9: If `pgood_in` does not rise within `PGOOD_TIMEOUT_MS` milliseconds of `pwr_en` rising, `pwr_en` drops, `attn_led` lights and event code 5 (power-good timeout) is emitted.
- R10: `aux_en` is high exactly when the latch is closed. If the latch opens while power is on or ramping, `pwr_en` and `aux_en` are low three cycles later, `attn_led` lights and event code 6 (forced off) is emitted.
- R11: A power indicator that stays dark for longer than one blink half period implies `pwr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_in | input | 1 | Attention button, high while pressed (asynchronous) |
| latch_open_in | input | 1 | Retention latch sensor, high when open (asynchronous) |
| present_in | input | 1 | Adapter presence, high when an adapter is seated (asynchronous) |
| pgood_in | input | 1 | Slot power good (asynchronous) |
| pwr_en | output | 1 | Main slot power enable |
| aux_en | output | 1 | Auxiliary power enable |
| pwr_led | output | 1 | Power indicator drive |
| attn_led | output | 1 | Attention indicator drive |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_code | output | 3 | Event code: 1 cancel, 2 add done, 3 remove done, 4 refused, 5 power-good timeout, 6 forced off |

## Verification
A press is taken 2 synchronizer cycles plus `DEBOUNCE_MS` ticks after the button edge. Because of the tick phase, this lands somewhere within one tick of jitter. The window results follow `CANCEL_MS` ticks later. Refusal, cancel and add-done events come one cycle after the cause is seen. The latch cut-off is due exactly three cycles after the input edge.

The bench holds the button for about three debounce periods. It samples levels only after the latest possible due cycle plus a margin, or, for in-window checks, before the earliest possible expiry. Events are matched in order by a scoreboard, whatever the exact cycle they arrive in, so the tick phase never decides a result.

// File: rtl/slot_attn_pkg.sv
package slot_attn_pkg;

   typedef enum logic [2:0] {
      ST_OFF      = 3'd0,
      ST_ADD_WAIT = 3'd1,
      ST_PWR_UP   = 3'd2,
      ST_ON       = 3'd3,
      ST_REM_WAIT = 3'd4
   } slot_state_e;

   localparam logic [2:0] EVT_CANCEL   = 3'd1;
   localparam logic [2:0] EVT_ADD_DONE = 3'd2;
   localparam logic [2:0] EVT_REM_DONE = 3'd3;
   localparam logic [2:0] EVT_REFUSED  = 3'd4;
   localparam logic [2:0] EVT_PG_TMO   = 3'd5;
   localparam logic [2:0] EVT_FORCED   = 3'd6;

endpackage

// File: rtl/slot_sync.sv
module slot_sync #(
   parameter int             WIDTH   = 1,
   parameter int             STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("slot_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
      end else begin
         stg_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/slot_tick_gen.sv
module slot_tick_gen #(
   parameter int DIV = 50000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);

   if (DIV < 1) begin : g_bad_div
      $error("slot_tick_gen: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every_cycle
      assign tick = 1'b1;
   end else begin : g_counted
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          cnt_q <= '0;
         else if (cnt_q == CW'(DIV - 1))      cnt_q <= '0;
         else                                 cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == CW'(DIV - 1));
   end

endmodule

// File: rtl/slot_debounce.sv
module slot_debounce #(
   parameter int HOLD_TICKS = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic din,
   output logic level,
   output logic rise
);

   if (HOLD_TICKS < 1) begin : g_bad_hold
      $error("slot_debounce: HOLD_TICKS must be at least 1");
   end

   localparam int HW = $clog2(HOLD_TICKS + 1);

   logic [HW-1:0] cnt_q;
   logic          lvl_q;
   logic          rise_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         lvl_q  <= 1'b0;
         rise_q <= 1'b0;
      end else begin
         rise_q <= 1'b0;
         if (din == lvl_q) begin
            cnt_q <= '0;
         end else if (tick) begin
            if (cnt_q == HW'(HOLD_TICKS - 1)) begin
               cnt_q  <= '0;
               lvl_q  <= din;
               rise_q <= din;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign level = lvl_q;
   assign rise  = rise_q;

endmodule

// File: rtl/slot_attn_seq.sv
module slot_attn_seq
   import slot_attn_pkg::*;
#(
   parameter int CLK_HZ           = 50_000_000,
   parameter int TICK_HZ          = 1000,
   parameter int SYNC_STAGES      = 2,
   parameter int DEBOUNCE_MS      = 20,
   parameter int CANCEL_MS        = 5000,
   parameter int BLINK_HALF_MS    = 500,
   parameter int PGOOD_TIMEOUT_MS = 100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       btn_in,
   input  logic       latch_open_in,
   input  logic       present_in,
   input  logic       pgood_in,
   output logic       pwr_en,
   output logic       aux_en,
   output logic       pwr_led,
   output logic       attn_led,
   output logic       evt_valid,
   output logic [2:0] evt_code
);

   localparam int DIV     = CLK_HZ / TICK_HZ;
   localparam int TMR_MAX = (CANCEL_MS > PGOOD_TIMEOUT_MS) ? CANCEL_MS : PGOOD_TIMEOUT_MS;
   localparam int TMR_W   = $clog2(TMR_MAX + 1);
   localparam int BLK_W   = $clog2(BLINK_HALF_MS + 1);

   if (TICK_HZ < 1 || CLK_HZ < TICK_HZ || (CLK_HZ % TICK_HZ) != 0) begin : g_bad_clk
      $error("slot_attn_seq: CLK_HZ must be a whole multiple of TICK_HZ");
   end
   if (CANCEL_MS < 1 || PGOOD_TIMEOUT_MS < 1 || BLINK_HALF_MS < 1) begin : g_bad_time
      $error("slot_attn_seq: window, timeout and blink periods must be nonzero");
   end

   // synchronized inputs: {btn, latch_open, present, pgood}; latch resets to open
   logic [3:0] raw_in, syn;
   logic       btn_s, latch_s, present_s, pgood_s;

   assign raw_in = {btn_in, latch_open_in, present_in, pgood_in};

   slot_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn)
   );

   assign {btn_s, latch_s, present_s, pgood_s} = syn;

   logic tick;
   slot_tick_gen #(.DIV(DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   logic btn_level, press;
   slot_debounce #(.HOLD_TICKS(DEBOUNCE_MS)) u_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .din   (btn_s),
      .level (btn_level),
      .rise  (press)
   );

   // free-running blink phase
   logic [BLK_W-1:0] blk_q;
   logic             blk_ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_q    <= '0;
         blk_ph_q <= 1'b0;
      end else if (tick) begin
         if (blk_q == BLK_W'(BLINK_HALF_MS - 1)) begin
            blk_q    <= '0;
            blk_ph_q <= ~blk_ph_q;
         end else begin
            blk_q <= blk_q + 1'b1;
         end
      end
   end

   // sequencer
   slot_state_e      st_q;
   logic [TMR_W-1:0] tmr_q;
   logic             fault_q;
   logic             evt_v_q;
   logic [2:0]       evt_c_q;
   logic             aux_q;
   logic             add_ok;
   logic             win_end;
   logic             pg_end;

   assign add_ok  = present_s & ~latch_s;
   assign win_end = tick && (tmr_q == TMR_W'(CANCEL_MS - 1));
   assign pg_end  = tick && (tmr_q == TMR_W'(PGOOD_TIMEOUT_MS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_OFF;
         tmr_q   <= '0;
         fault_q <= 1'b0;
         evt_v_q <= 1'b0;
         evt_c_q <= '0;
         aux_q   <= 1'b0;
      end else begin
         evt_v_q <= 1'b0;
         aux_q   <= ~latch_s;
         if (tick) tmr_q <= tmr_q + 1'b1;
         unique case (st_q)
            ST_OFF: begin
               if (press) begin
                  tmr_q <= '0;
                  if (add_ok) begin
                     fault_q <= 1'b0;
                     st_q    <= ST_ADD_WAIT;
                  end else begin
                     fault_q <= 1'b1;
                     evt_v_q <= 1'b1;
                     evt_c_q <= EVT_REFUSED;
                  end
               end
            end
            ST_ADD_WAIT: begin
               if (press) begin
                  st_q    <= ST_OFF;
                  evt_v_q <= 1'b1;
                  evt_c_q <= EVT_CANCEL;
               end else if (win_end) begin
                  tmr_q <= '0;
                  if (add_ok) begin
                     st_q <= ST_PWR_UP;
                  end else begin
                     st_q    <= ST_OFF;
                     fault_q <= 1'b1;
                     evt_v_q <= 1'b1;
                     evt_c_q <= EVT_REFUSED;
                  end
               end
            end
            ST_PWR_UP: begin
               if (latch_s) begin
                  st_q    <= ST_OFF;
                  fault_q <= 1'b1;
                  evt_v_q <= 1'b1;
                  evt_c_q <= EVT_FORCED;
               end else if (pgood_s) begin
                  st_q    <= ST_ON;
                  evt_v_q <= 1'b1;
                  evt_c_q <= EVT_ADD_DONE;
               end else if (pg_end) begin
                  st_q    <= ST_OFF;
                  fault_q <= 1'b1;
                  evt_v_q <= 1'b1;
                  evt_c_q <= EVT_PG_TMO;
               end
            end
            ST_ON: begin
               if (latch_s) begin
                  st_q    <= ST_OFF;
                  fault_q <= 1'b1;
                  evt_v_q <= 1'b1;
                  evt_c_q <= EVT_FORCED;
               end else if (press) begin
                  tmr_q <= '0;
                  st_q  <= ST_REM_WAIT;
               end
            end
            ST_REM_WAIT: begin
               if (latch_s) begin
                  st_q    <= ST_OFF;
                  fault_q <= 1'b1;
                  evt_v_q <= 1'b1;
                  evt_c_q <= EVT_FORCED;
               end else if (press) begin
                  st_q    <= ST_ON;
                  evt_v_q <= 1'b1;
                  evt_c_q <= EVT_CANCEL;
               end else if (win_end) begin
                  st_q    <= ST_OFF;
                  evt_v_q <= 1'b1;
                  evt_c_q <= EVT_REM_DONE;
               end
            end
            default: st_q <= ST_OFF;
         endcase
      end
   end

   logic blinking;
   assign blinking  = (st_q == ST_ADD_WAIT) || (st_q == ST_PWR_UP) || (st_q == ST_REM_WAIT);
   assign pwr_en    = (st_q == ST_PWR_UP) || (st_q == ST_ON) || (st_q == ST_REM_WAIT);
   assign pwr_led   = (st_q == ST_ON) || (blinking && blk_ph_q);
   assign attn_led  = fault_q;
   assign aux_en    = aux_q;
   assign evt_valid = evt_v_q;
   assign evt_code  = evt_c_q;

   logic unused_lvl;
   assign unused_lvl = btn_level;

endmodule

// File: rtl/slot_attn_chk.sv
module slot_attn_chk #(
   parameter int CLK_HZ        = 50_000_000,
   parameter int TICK_HZ       = 1000,
   parameter int BLINK_HALF_MS = 500
) (
   input logic       clk,
   input logic       rst_n,
   input logic       latch_open_in,
   input logic       pwr_en,
   input logic       aux_en,
   input logic       pwr_led,
   input logic       attn_led,
   input logic       evt_valid,
   input logic [2:0] evt_code
);

   localparam int DARK_LIMIT = BLINK_HALF_MS * (CLK_HZ / TICK_HZ) + 2;

   int dark_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      dark_run <= 0;
      else if (pwr_led)                dark_run <= 0;
      else if (dark_run <= DARK_LIMIT) dark_run <= dark_run + 1;
   end

   // R6: a cancel never changes main power
   assert_cancel_keeps_power_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_code == 3'd1) |-> $stable(pwr_en));

   // R5: add done comes with power and a solid indicator
   assert_add_done_lit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_code == 3'd2) |-> (pwr_en && pwr_led));

   // R7: remove done leaves the slot dark and unpowered
   assert_rem_done_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_code == 3'd3) |-> (!pwr_en && !pwr_led));

   // R8: refusal keeps power off and lights attention
   assert_refuse_attn_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_code == 3'd4) |-> (!pwr_en && attn_led));

   // R9: power-good timeout removes power and lights attention
   assert_pg_timeout_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_code == 3'd5) |-> (!pwr_en && attn_led));

   // R10: latch open for four samples means both supplies are cut
   assert_latch_cut_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_open_in && $past(latch_open_in) && $past(latch_open_in, 2) && $past(latch_open_in, 3))
      |-> (!pwr_en && !aux_en));

   // R11: a steadily dark power indicator means the slot is unpowered
   assert_dark_means_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (dark_run > DARK_LIMIT) |-> !pwr_en);

endmodule

bind slot_attn_seq slot_attn_chk #(
   .CLK_HZ        (CLK_HZ),
   .TICK_HZ       (TICK_HZ),
   .BLINK_HALF_MS (BLINK_HALF_MS)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .latch_open_in (latch_open_in),
   .pwr_en        (pwr_en),
   .aux_en        (aux_en),
   .pwr_led       (pwr_led),
   .attn_led      (attn_led),
   .evt_valid     (evt_valid),
   .evt_code      (evt_code)
);

// File: tb/slot_attn_seq_bench.sv
`timescale 1ns/1ps
module slot_attn_seq_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       btn_in = 1'b0;
   logic       latch_open_in = 1'b0;
   logic       present_in = 1'b0;
   logic       pgood_in = 1'b0;
   logic       pwr_en, aux_en, pwr_led, attn_led, evt_valid;
   logic [2:0] evt_code;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   int exp_q[$];

   always #10 clk = ~clk;   // 50 MHz

   slot_attn_seq #(
      .CLK_HZ(4000), .TICK_HZ(1000), .SYNC_STAGES(2), .DEBOUNCE_MS(3),
      .CANCEL_MS(40), .BLINK_HALF_MS(4), .PGOOD_TIMEOUT_MS(20)
   ) u_slot_attn_seq (
      .clk(clk), .rst_n(rst_n), .btn_in(btn_in), .latch_open_in(latch_open_in),
      .present_in(present_in), .pgood_in(pgood_in), .pwr_en(pwr_en), .aux_en(aux_en),
      .pwr_led(pwr_led), .attn_led(attn_led), .evt_valid(evt_valid), .evt_code(evt_code)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic expect_evt(input int code);
      exp_q.push_back(code);
   endtask

   task automatic press();
      btn_in = 1'b1; step(40);
      btn_in = 1'b0; step(40);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && evt_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL event-order R2 actual=%0d expected=none", evt_code);
         end else begin
            int e;
            e = exp_q.pop_front();
            if (int'(evt_code) != e) begin
               errors++;
               $display("FAIL event-order actual=%0d expected=%0d", evt_code, e);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      step(5);
      check("R1 pwr_en", pwr_en, 0);
      check("R1 pwr_led", pwr_led, 0);
      check("R1 attn_led", attn_led, 0);
      check("R1 evt_valid", evt_valid, 0);
      rst_n = 1'b1;
      step(5);
      check("R10 aux_en latch closed", aux_en, 1);

      // R2: short glitch ignored
      btn_in = 1'b1; step(6); btn_in = 1'b0;
      step(100);
      check("R2 glitch pwr_en", pwr_en, 0);
      check("R2 glitch pwr_led", pwr_led, 0);

      // R3 R4 R5: hot-add
      present_in = 1'b1; pgood_in = 1'b1;
      expect_evt(2);
      press();
      check("R4 no power in window", pwr_en, 0);
      begin
         int flips = 0;
         logic prev = pwr_led;
         for (int i = 0; i < 30; i++) begin
            step(2);
            if (pwr_en) check("R4 power in window", pwr_en, 0);
            if (pwr_led != prev) flips++;
            prev = pwr_led;
         end
         check("R4 blink toggles", (flips >= 2), 1);
      end
      step(200);
      check("R3 power after window", pwr_en, 1);
      check("R5 solid led", pwr_led, 1);

      // R6: cancel a hot-remove
      expect_evt(1);
      press(); press();
      step(200);
      check("R6 power kept", pwr_en, 1);
      check("R6 led restored", pwr_led, 1);

      // R7 R11: hot-remove
      expect_evt(3);
      press();
      step(200);
      check("R7 power off", pwr_en, 0);
      check("R7 led off", pwr_led, 0);
      check("R11 dark implies unpowered", pwr_en, 0);

      // R8: refusal without adapter
      present_in = 1'b0;
      expect_evt(4);
      press();
      check("R8 attn lit", attn_led, 1);
      check("R8 no power", pwr_en, 0);

      // R8 attn cleared, then R6 cancel of a hot-add
      present_in = 1'b1;
      expect_evt(1);
      press();
      check("R8 attn cleared", attn_led, 0);
      press();
      step(200);
      check("R6 add cancel power", pwr_en, 0);
      check("R6 add cancel led", pwr_led, 0);

      // R8: refusal at window end after latch opens
      expect_evt(4);
      press();
      latch_open_in = 1'b1;
      step(200);
      check("R8 late refuse power", pwr_en, 0);
      check("R8 late refuse attn", attn_led, 1);
      latch_open_in = 1'b0;
      step(10);

      // R9: power-good timeout
      pgood_in = 1'b0;
      expect_evt(5);
      press();
      step(300);
      check("R9 power dropped", pwr_en, 0);
      check("R9 attn lit", attn_led, 1);

      // R10: forced off by latch
      pgood_in = 1'b1;
      expect_evt(2);
      press();
      step(200);
      check("R10 powered first", pwr_en, 1);
      expect_evt(6);
      latch_open_in = 1'b1;
      step(5);
      check("R10 pwr_en cut", pwr_en, 0);
      check("R10 aux_en cut", aux_en, 0);
      check("R10 attn lit", attn_led, 1);
      latch_open_in = 1'b0;
      step(5);
      check("R10 aux_en restored", aux_en, 1);

      step(50);
      while (exp_q.size() > 0) begin
         int e;
         e = exp_q.pop_front();
         checks++; errors++;
         $display("FAIL missing-event actual=none expected=%0d", e);
      end
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule